// File: doc/BRIEF.md
# Interrupt Flag and Request Controller

This block gathers six single-cycle event pulses (periodic tick, alarm match, update end, wake-up, kickstart and RAM clear) into latched flags. It weighs each flag against its own enable bit and drives an active-low, open-drain interrupt request line. The line is modelled as a drive-low enable: while it is 1 the pad pulls the line low, and while it is 0 the pad floats.

The periodic, alarm and update-end flags sit in a status byte that clears itself when a read of it completes. While a read is in progress the byte holds still. An event that lands during the read is parked and becomes visible once the read has finished, so no event is lost. The wake-up, kickstart and RAM-clear flags form a separate group. A read leaves them alone, and software clears any one of them only by writing a 0 to its bit. The block does not create the events itself. Software reaches it through a status read strobe, an enable register write port and an extended-flag write port.

Top module: `irqc_top`

## Requirements
- R1: The source order on `ev_i`, `en_wdata` and `en_q` is bit 0 periodic, bit 1 alarm, bit 2 update-end, bit 3 wake-up, bit 4 kickstart and bit 5 RAM-clear. The summary equals the OR over all six sources of (flag AND enable), and `irq_drive_low` equals the summary.
- R2: `stat_rdata` carries the summary in bit 7, the periodic flag in bit 6, the alarm flag in bit 5 and the update-end flag in bit 4. Bits 3 to 0 always read 0.
- R3: An event pulse sets its flag at the next clock edge whatever its enable bit holds. `xf_q` reports the extended flags as bit 0 wake-up, bit 1 kickstart and bit 2 RAM-clear.
- R4: A read is the span of cycles in which `stat_rd` is 1. On the first cycle after `stat_rd` returns to 0, the periodic, alarm and update-end flags read 0 unless an event was parked for them.
- R5: While `stat_rd` is 1, flag bits 6 to 4 of `stat_rdata` do not change. An event that arrives during the read appears in the flags on the cycle after the read ends.
- R6: The extended flags are not cleared by a status read. Writing 0 to a bit through `xf_wr` clears that bit at the next edge.
- R7: Writing 1 to an extended-flag bit has no effect. An event on the same cycle as a clearing write leaves its flag set.
- R8: If a flag is already set when its enable bit is written to 1, `irq_drive_low` is 1 on the cycle after the write.
- R9: After reset all flags and enables are 0. `irq_drive_low` is 0 whenever no enabled flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_i | input | 6 | Event pulses, one per source |
| stat_rd | input | 1 | Status read in progress (level) |
| stat_rdata | output | 8 | Status byte: summary and the three clear-on-read flags |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | 6 | Enable register write data |
| en_q | output | 6 | Current enable bits |
| xf_wr | input | 1 | Extended-flag write strobe |
| xf_wdata | input | 3 | Extended-flag write data (0 clears a bit, 1 keeps it) |
| xf_q | output | 3 | Current extended flags |
| irq_drive_low | output | 1 | 1 pulls the open-drain request line low |

## Verification
The assertions assume that `ev_i` bits are single-cycle pulses sampled synchronously and that `stat_rd` is a clean level that is high for at least one cycle per read. The bench drives all inputs one time unit after the rising edge and keeps each event pulse and write strobe to one cycle. It opens and closes every read with a plain level change, so the freeze property only ever sees well-formed read spans.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int NUM_COR = 3;
    localparam int NUM_W0C = 3;
    localparam int NUM_SRC = NUM_COR + NUM_W0C;
    localparam int STAT_W  = 8;
    localparam int PAD_W   = STAT_W - 1 - NUM_COR;

    typedef struct packed {
        logic [NUM_W0C-1:0] w0c;
        logic [NUM_COR-1:0] cor;
    } src_vec_t;

    function automatic logic [STAT_W-1:0] pack_status(input logic summ,
                                                      input logic [NUM_COR-1:0] cor);
        logic [STAT_W-1:0] r;
        r = '0;
        r[STAT_W-1] = summ;
        for (int k = 0; k < NUM_COR; k++) begin
            r[STAT_W-2-k] = cor[k];
        end
        return r;
    endfunction

endpackage

// File: rtl/irqc_cor_flags.sv
module irqc_cor_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] ev_i,
    input  logic         rd_i,
    output logic [N-1:0] flags_o
);
    logic [N-1:0] flags_q;
    logic [N-1:0] park_q;
    logic         rd_q;
    logic         rd_done;

    assign rd_done = rd_q && !rd_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            park_q  <= '0;
            rd_q    <= 1'b0;
        end else begin
            rd_q <= rd_i;
            if (rd_i) begin
                park_q <= park_q | ev_i;
            end else if (rd_done) begin
                flags_q <= park_q | ev_i;
                park_q  <= '0;
            end else begin
                flags_q <= flags_q | ev_i;
            end
        end
    end

    assign flags_o = flags_q;

    // R5
    read_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_i && rd_q) |-> $stable(flags_q));

    // R3
    set_outside_read_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_i && !rd_q && (|ev_i)) |=> ((flags_q & $past(ev_i)) == $past(ev_i)));

endmodule

// File: rtl/irqc_w0c_flags.sv
module irqc_w0c_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] ev_i,
    input  logic         wr_i,
    input  logic [N-1:0] wdata_i,
    output logic [N-1:0] flags_o
);
    logic [N-1:0] flags_q;
    logic [N-1:0] keep_mask;

    assign keep_mask = wr_i ? wdata_i : '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            flags_q <= (flags_q & keep_mask) | ev_i;
        end
    end

    assign flags_o = flags_q;

    // R6
    hold_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_i && !(|ev_i)) |=> $stable(flags_q));

    // R7
    write_one_noop_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_i && (&wdata_i) && !(|ev_i)) |=> $stable(flags_q));

endmodule

// File: rtl/irqc_summary.sv
module irqc_summary #(
    parameter int N = 6
) (
    input  logic [N-1:0] flags_i,
    input  logic [N-1:0] en_i,
    output logic         any_o
);
    logic [N-1:0] term;

    for (genvar k = 0; k < N; k++) begin : g_term
        assign term[k] = flags_i[k] & en_i[k];
    end

    assign any_o = |term;

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_SRC-1:0]  ev_i,
    input  logic                stat_rd,
    output logic [STAT_W-1:0]   stat_rdata,
    input  logic                en_wr,
    input  logic [NUM_SRC-1:0]  en_wdata,
    output logic [NUM_SRC-1:0]  en_q,
    input  logic                xf_wr,
    input  logic [NUM_W0C-1:0]  xf_wdata,
    output logic [NUM_W0C-1:0]  xf_q,
    output logic                irq_drive_low
);
    src_vec_t           ev_s;
    src_vec_t           flag_s;
    logic [NUM_SRC-1:0] en_r;
    logic               summ;

    assign ev_s = src_vec_t'(ev_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_r <= '0;
        end else if (en_wr) begin
            en_r <= en_wdata;
        end
    end

    irqc_cor_flags #(.N(NUM_COR)) cor_i (
        .clk     (clk),
        .rst     (rst),
        .ev_i    (ev_s.cor),
        .rd_i    (stat_rd),
        .flags_o (flag_s.cor)
    );

    irqc_w0c_flags #(.N(NUM_W0C)) w0c_i (
        .clk     (clk),
        .rst     (rst),
        .ev_i    (ev_s.w0c),
        .wr_i    (xf_wr),
        .wdata_i (xf_wdata),
        .flags_o (flag_s.w0c)
    );

    irqc_summary #(.N(NUM_SRC)) sum_i (
        .flags_i (flag_s),
        .en_i    (en_r),
        .any_o   (summ)
    );

    assign stat_rdata    = pack_status(summ, flag_s.cor);
    assign en_q          = en_r;
    assign xf_q          = flag_s.w0c;
    assign irq_drive_low = summ;

    // R9
    no_enable_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(|en_r) |-> !irq_drive_low);

    // R9
    no_flag_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(|flag_s) |-> !irq_drive_low);

    // R2
    stat_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
        stat_rdata[PAD_W-1:0] == '0);

    // R8
    enable_set_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (en_wr && !stat_rd && !xf_wr && (|(en_wdata & flag_s))) |=> irq_drive_low);

endmodule

// File: tb/irqc_top_tb_top.sv
module irqc_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic [5:0] ev_i;
    logic       stat_rd;
    logic [7:0] stat_rdata;
    logic       en_wr;
    logic [5:0] en_wdata;
    logic [5:0] en_q;
    logic       xf_wr;
    logic [2:0] xf_wdata;
    logic [2:0] xf_q;
    logic       irq_drive_low;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irqc_top dut_i (
        .clk(clk), .rst(rst), .ev_i(ev_i), .stat_rd(stat_rd), .stat_rdata(stat_rdata),
        .en_wr(en_wr), .en_wdata(en_wdata), .en_q(en_q), .xf_wr(xf_wr),
        .xf_wdata(xf_wdata), .xf_q(xf_q), .irq_drive_low(irq_drive_low)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic pulse_ev(input logic [5:0] v);
        ev_i = v; tick(); ev_i = '0;
    endtask

    task automatic write_en(input logic [5:0] v);
        en_wr = 1'b1; en_wdata = v; tick(); en_wr = 1'b0;
    endtask

    task automatic write_xf(input logic [2:0] v);
        xf_wr = 1'b1; xf_wdata = v; tick(); xf_wr = 1'b0;
    endtask

    task automatic do_read();
        stat_rd = 1'b1; tick(); stat_rd = 1'b0; tick();
    endtask

    task automatic t_reset();
        chk("R9", "status after reset", stat_rdata, 8'h00);
        chk("R9", "xflags after reset", {5'b0, xf_q}, 8'h00);
        chk("R9", "enables after reset", {2'b0, en_q}, 8'h00);
        chk("R9", "irq after reset", {7'b0, irq_drive_low}, 8'h00);
    endtask

    task automatic t_set_no_enable();
        pulse_ev(6'b111111);
        chk("R3", "status flags w/o enable", stat_rdata, 8'h70);
        chk("R3", "xflags w/o enable", {5'b0, xf_q}, 8'h07);
        chk("R9", "irq with no enables", {7'b0, irq_drive_low}, 8'h00);
    endtask

    task automatic t_enable_late();
        write_en(6'b000001);
        chk("R8", "irq after enabling set periodic", {7'b0, irq_drive_low}, 8'h01);
        chk("R2", "status with summary", stat_rdata, 8'hF0);
    endtask

    task automatic t_read_clear();
        stat_rd = 1'b1; tick();
        chk("R5", "status frozen during read", stat_rdata, 8'hF0);
        stat_rd = 1'b0; tick();
        chk("R4", "status after read", stat_rdata, 8'h00);
        chk("R6", "xflags survive read", {5'b0, xf_q}, 8'h07);
        chk("R1", "irq after clear", {7'b0, irq_drive_low}, 8'h00);
    endtask

    task automatic t_deferred();
        stat_rd = 1'b1; tick();
        ev_i = 6'b000001; tick(); ev_i = '0;
        chk("R5", "event during read hidden", stat_rdata, 8'h00);
        stat_rd = 1'b0; tick();
        chk("R5", "parked event after read", stat_rdata, 8'hC0);
        chk("R1", "irq from parked event", {7'b0, irq_drive_low}, 8'h01);
        do_read();
        chk("R4", "second read clears", stat_rdata, 8'h00);
    endtask

    task automatic t_w0c();
        write_xf(3'b111);
        chk("R7", "write ones no effect", {5'b0, xf_q}, 8'h07);
        write_xf(3'b110);
        chk("R6", "write zero clears wake", {5'b0, xf_q}, 8'h06);
        write_en(6'b001000);
        chk("R1", "wake enabled but clear", {7'b0, irq_drive_low}, 8'h00);
        write_en(6'b010000);
        chk("R8", "kick enabled while set", {7'b0, irq_drive_low}, 8'h01);
        write_xf(3'b101);
        chk("R6", "kick cleared", {5'b0, xf_q}, 8'h04);
        chk("R9", "irq released", {7'b0, irq_drive_low}, 8'h00);
        ev_i = 6'b001000; xf_wr = 1'b1; xf_wdata = 3'b000; tick();
        ev_i = '0; xf_wr = 1'b0;
        chk("R7", "event beats clearing write", {5'b0, xf_q}, 8'h01);
    endtask

    task automatic t_combo();
        write_en(6'b000010);
        pulse_ev(6'b000010);
        chk("R1", "alarm enabled", {7'b0, irq_drive_low}, 8'h01);
        write_en(6'b000100);
        chk("R1", "alarm set, update enabled", {7'b0, irq_drive_low}, 8'h00);
        pulse_ev(6'b000100);
        chk("R2", "alarm+update status", stat_rdata, 8'hB0);
        write_en(6'b100000);
        pulse_ev(6'b100000);
        chk("R1", "ramclr enabled", {7'b0, irq_drive_low}, 8'h01);
        chk("R3", "ramclr xflag", {5'b0, xf_q}, 8'h05);
    endtask

    initial begin
        rst = 1'b1; ev_i = '0; stat_rd = 1'b0; en_wr = 1'b0; en_wdata = '0;
        xf_wr = 1'b0; xf_wdata = '0;
        tick(); tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_set_no_enable();
        t_enable_late();
        t_read_clear();
        t_deferred();
        t_w0c();
        t_combo();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule